// File: doc/BRIEF.md
# Temperature-Driven Fan PWM Controller

This block turns a stream of signed die-temperature samples into a slow pulse-width drive for a cooling fan, and raises two alarm flags at higher temperatures. Each accepted sample sets a target duty. The fan stays off while the temperature is at or below a programmable start point. Just above that point the target steps up to a fixed minimum of 40 %. It then climbs linearly with a programmable slope, in percent per degree, and stops at 100 %. The duty actually driven onto the pin follows the target by at most one percent per one-second tick, so the fan's pitch never jumps.

Two comparators with hysteresis watch the same samples. The first asks the system to slow its clocks. The second calls for a system shutdown and at once forces the fan to full drive. Temperatures are whole degrees Celsius in two's complement. The sample input is a valid/ready stream whose ready is always high, so the producer never sees back-pressure. A sample transfers on every clock edge at which valid is high. The configuration pins are plain levels and are read whenever a sample transfers.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: A sample with temperature less than or equal to the start point sets the target duty to 0 %; once the applied duty has reached it, the PWM pin stays low for whole frames.
- R2: A sample above the start point sets the target to 40 % plus slope times the difference, so with a slope of 0 the fan settles at exactly 40 %.
- R3: The target grows by the slope (percent per degree) for each degree above the start point and is clamped at 100 %.
- R4: The applied duty changes only on the one-second tick, which occurs once every SEC_DIV clocks, and each tick moves it by exactly 1 % toward the target, both upward and downward.
- R5: A PWM frame is 100 slots of FRAME_DIV clocks each. The pin is high for the first N slots, where N is the driven duty in percent, so 100 % is a constant high and 0 % is a constant low.
- R6: When temp_valid is low, temp_data is ignored; the target and the alarm flags keep the values set by the last accepted sample.
- R7: throttle_out sets on a sample at or above the throttle threshold. It clears on a sample at or below that threshold minus 2 °C, and holds in between.
- R8: shutdown_out sets and clears by the same rule against the shutdown threshold. While it is set, the pin is driven at 100 % no matter what the applied duty is.
- R9: While reset is asserted the applied duty and target are 0 %, the pin is low, and both alarm flags are low.
- R10: temp_ready is high in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_valid | input | 1 | Sample stream valid |
| temp_ready | output | 1 | Sample stream ready, always high |
| temp_data | input | TEMP_W | Signed temperature sample in °C |
| cfg_t_start | input | TEMP_W | Signed fan start point in °C |
| cfg_slope | input | SLOPE_W | Ramp slope in percent per °C |
| cfg_t_throttle | input | TEMP_W | Signed clock-throttle threshold in °C |
| cfg_t_shutdown | input | TEMP_W | Signed shutdown threshold in °C |
| pwm_out | output | 1 | Fan PWM drive |
| throttle_out | output | 1 | Clock-throttle request |
| shutdown_out | output | 1 | System-shutdown request |

## Verification
Several properties are checked on every cycle. The applied duty never moves except on a tick and never by more than one step. The target stays within 0 to 100 and is zero after a sample at or below the start point. The alarm flags hold when no sample arrives, and a set shutdown flag drives the pin high. Other properties can only be shown by the bench's scenarios, because they need whole frames or many seconds of time. These are the exact settled duty for each profile segment (minimum step, linear ramp, clamp), the slew rate measured over ten seconds in each direction, the behaviour of the hysteresis band across several samples, and the shutdown override seen as a full frame of high output.

// File: rtl/fan_ctrl_pkg.sv
package fan_ctrl_pkg;
  localparam int DUTY_W     = 7;
  localparam int FULL_DUTY  = 100;
  localparam int START_DUTY = 40;
  localparam int HYST_C     = 2;
  typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/fan_duty_target.sv
module fan_duty_target
  import fan_ctrl_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int SLOPE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [TEMP_W-1:0] smp_temp,
  input  logic signed [TEMP_W-1:0] t_start,
  input  logic [SLOPE_W-1:0]       slope,
  output duty_t                    target
);
  localparam int PW = TEMP_W + SLOPE_W + 1;

  logic signed [TEMP_W:0] diff;
  logic                   above;
  logic [PW-1:0]          ramp;
  duty_t                  next_target;

  always_comb begin
    diff  = $signed({smp_temp[TEMP_W-1], smp_temp}) - $signed({t_start[TEMP_W-1], t_start});
    above = !diff[TEMP_W] && (diff != '0);
    ramp  = PW'(diff[TEMP_W-1:0]) * PW'(slope) + PW'(START_DUTY);
    if (!above)
      next_target = '0;
    else if (ramp >= PW'(FULL_DUTY))
      next_target = duty_t'(FULL_DUTY);
    else
      next_target = duty_t'(ramp);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      target <= '0;
    else if (smp_valid)
      target <= next_target;
  end

  assert_target_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_temp <= t_start)) |=> (target == '0));

  assert_target_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_temp > t_start)) |=> (target >= duty_t'(START_DUTY)));

  assert_target_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
    target <= duty_t'(FULL_DUTY));

  assert_target_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(target));
endmodule

// File: rtl/fan_duty_slew.sv
module fan_duty_slew
  import fan_ctrl_pkg::*;
#(
  parameter int SEC_DIV = 100_000_000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  duty_t target,
  output duty_t applied
);
  localparam int CW = (SEC_DIV > 2) ? $clog2(SEC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEC_DIV - 1);

  logic [CW-1:0] sec_cnt;
  logic          tick;

  assign tick = (sec_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)
      sec_cnt <= '0;
    else if (tick)
      sec_cnt <= '0;
    else
      sec_cnt <= sec_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      applied <= '0;
    else if (tick) begin
      if (applied < target)
        applied <= applied + 1'b1;
      else if (applied > target)
        applied <= applied - 1'b1;
    end
  end

  assert_slew_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(applied));

  assert_slew_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((applied <= $past(applied) + 1'b1) && ($past(applied) <= applied + 1'b1)));

  assert_slew_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    applied <= duty_t'(FULL_DUTY));
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_ctrl_pkg::*;
#(
  parameter int FRAME_DIV = 33_333
) (
  input  logic  clk,
  input  logic  rst_n,
  input  duty_t duty,
  output logic  pwm
);
  localparam int PW = (FRAME_DIV > 2) ? $clog2(FRAME_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(FRAME_DIV - 1);
  localparam duty_t         SLOT_LAST = duty_t'(FULL_DUTY - 1);

  logic [PW-1:0] pre_cnt;
  duty_t         slot;
  logic          step;

  assign step = (pre_cnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      slot    <= '0;
    end else begin
      pre_cnt <= step ? '0 : pre_cnt + 1'b1;
      if (step)
        slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pwm <= 1'b0;
    else
      pwm <= (slot < duty);
  end

  assert_slot_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SLOT_LAST);

  assert_pwm_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> !pwm);
endmodule

// File: rtl/fan_alarm.sv
module fan_alarm
  import fan_ctrl_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [TEMP_W-1:0] smp_temp,
  input  logic signed [TEMP_W-1:0] thr,
  output logic                     flag
);
  logic signed [TEMP_W:0] t_w;
  logic signed [TEMP_W:0] set_w;
  logic signed [TEMP_W:0] clr_w;

  always_comb begin
    t_w   = $signed({smp_temp[TEMP_W-1], smp_temp});
    set_w = $signed({thr[TEMP_W-1], thr});
    clr_w = set_w - $signed((TEMP_W+1)'(HYST_C));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (smp_valid) begin
      if (t_w >= set_w)
        flag <= 1'b1;
      else if (t_w <= clr_w)
        flag <= 1'b0;
    end
  end

  assert_alarm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(flag));

  assert_alarm_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_temp >= thr)) |=> flag);
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_ctrl_pkg::*;
#(
  parameter int TEMP_W    = 8,
  parameter int SLOPE_W   = 4,
  parameter int FRAME_DIV = 33_333,
  parameter int SEC_DIV   = 100_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     temp_valid,
  output logic                     temp_ready,
  input  logic signed [TEMP_W-1:0] temp_data,
  input  logic signed [TEMP_W-1:0] cfg_t_start,
  input  logic [SLOPE_W-1:0]       cfg_slope,
  input  logic signed [TEMP_W-1:0] cfg_t_throttle,
  input  logic signed [TEMP_W-1:0] cfg_t_shutdown,
  output logic                     pwm_out,
  output logic                     throttle_out,
  output logic                     shutdown_out
);
  localparam int N_ALARM = 2;

  duty_t target;
  duty_t applied;
  duty_t duty_eff;
  logic  xfer;
  logic [N_ALARM-1:0]             alarm_flag;
  logic [N_ALARM-1:0][TEMP_W-1:0] alarm_thr;

  assign temp_ready = 1'b1;
  assign xfer       = temp_valid && temp_ready;

  fan_duty_target #(.TEMP_W(TEMP_W), .SLOPE_W(SLOPE_W)) u_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (xfer),
    .smp_temp  (temp_data),
    .t_start   (cfg_t_start),
    .slope     (cfg_slope),
    .target    (target)
  );

  fan_duty_slew #(.SEC_DIV(SEC_DIV)) u_slew (
    .clk     (clk),
    .rst_n   (rst_n),
    .target  (target),
    .applied (applied)
  );

  assign alarm_thr = {cfg_t_shutdown, cfg_t_throttle};

  for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
    fan_alarm #(.TEMP_W(TEMP_W)) u_alarm (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (xfer),
      .smp_temp  (temp_data),
      .thr       ($signed(alarm_thr[g])),
      .flag      (alarm_flag[g])
    );
  end

  assign throttle_out = alarm_flag[0];
  assign shutdown_out = alarm_flag[1];
  assign duty_eff     = shutdown_out ? duty_t'(FULL_DUTY) : applied;

  fan_pwm_gen #(.FRAME_DIV(FRAME_DIV)) u_pwm (
    .clk   (clk),
    .rst_n (rst_n),
    .duty  (duty_eff),
    .pwm   (pwm_out)
  );

  assert_shutdown_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_out |=> pwm_out);

  assert_shutdown_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid && (temp_data <= cfg_t_shutdown - 8'sd2)) |=> !shutdown_out);
endmodule

// File: tb/test_fan_pwm_ctrl.sv
module test_fan_pwm_ctrl;
  localparam int FRAME_DIV = 2;
  localparam int SEC_DIV   = 300;
  localparam int WIN       = 100 * FRAME_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic temp_valid = 1'b0;
  logic temp_ready;
  logic signed [7:0] temp_data = '0;
  logic signed [7:0] cfg_t_start = 8'sd30;
  logic [3:0]        cfg_slope = 4'd0;
  logic signed [7:0] cfg_t_throttle = 8'sd70;
  logic signed [7:0] cfg_t_shutdown = 8'sd90;
  logic pwm_out, throttle_out, shutdown_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fan_pwm_ctrl #(.TEMP_W(8), .SLOPE_W(4), .FRAME_DIV(FRAME_DIV), .SEC_DIV(SEC_DIV)) i_fan_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_ready(temp_ready),
    .temp_data(temp_data), .cfg_t_start(cfg_t_start), .cfg_slope(cfg_slope),
    .cfg_t_throttle(cfg_t_throttle), .cfg_t_shutdown(cfg_t_shutdown),
    .pwm_out(pwm_out), .throttle_out(throttle_out), .shutdown_out(shutdown_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic send(input int t);
    @(negedge clk);
    temp_data  = 8'(t);
    temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_sec(input int s);
    repeat (s * SEC_DIV) @(negedge clk);
  endtask

  task automatic measure(output int duty, output int high);
    high = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (pwm_out) high++;
    end
    duty = high / FRAME_DIV;
  endtask

  task automatic t_reset;
    int d, h;
    @(negedge clk);
    check("R9 pwm in reset", int'(pwm_out), 0);
    check("R9 throttle in reset", int'(throttle_out), 0);
    check("R9 shutdown in reset", int'(shutdown_out), 0);
    check("R10 ready in reset", int'(temp_ready), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    measure(d, h);
    check("R9 duty after reset", d, 0);
    check("R10 ready after reset", int'(temp_ready), 1);
  endtask

  task automatic t_below;
    int d, h;
    send(30);
    send(25);
    wait_sec(5);
    measure(d, h);
    check("R1 at/below start", h, 0);
  endtask

  task automatic t_start_step;
    int d, h;
    cfg_slope = 4'd0;
    send(35);
    wait_sec(45);
    measure(d, h);
    check("R2 minimum step", d, 40);
    check("R5 high clocks at 40", h, 40 * FRAME_DIV);
  endtask

  task automatic t_linear;
    int d, h;
    cfg_slope = 4'd5;
    send(34);
    wait_sec(25);
    measure(d, h);
    check("R3 linear 34C slope5", d, 60);
  endtask

  task automatic t_slew_up;
    int d1, d2, h;
    send(60);
    measure(d1, h);
    repeat (10 * SEC_DIV - WIN) @(negedge clk);
    measure(d2, h);
    check_range("R4 rise over 10s", d2 - d1, 9, 11);
    wait_sec(45);
    measure(d1, h);
    check("R3 clamp at 100", d1, 100);
    check("R5 constant high", h, WIN);
  endtask

  task automatic t_hold;
    int d, h;
    @(negedge clk);
    temp_data = 8'sd20;
    wait_sec(10);
    measure(d, h);
    check("R6 ignored without valid", d, 100);
    check("R6 flags held", int'(throttle_out), 0);
  endtask

  task automatic t_throttle;
    send(70);
    check("R7 set at threshold", int'(throttle_out), 1);
    send(69);
    check("R7 hold in band", int'(throttle_out), 1);
    send(68);
    check("R7 clear at thr-2", int'(throttle_out), 0);
  endtask

  task automatic t_slew_down;
    int d1, d2, h;
    send(20);
    measure(d1, h);
    repeat (10 * SEC_DIV - WIN) @(negedge clk);
    measure(d2, h);
    check_range("R4 fall over 10s", d1 - d2, 9, 11);
    wait_sec(100);
    measure(d1, h);
    check("R1 back to off", h, 0);
  endtask

  task automatic t_shutdown;
    int d, h;
    cfg_t_start = 8'sd100;
    send(90);
    check("R8 set at threshold", int'(shutdown_out), 1);
    measure(d, h);
    check("R8 forced full drive", h, WIN);
    send(89);
    check("R8 hold in band", int'(shutdown_out), 1);
    send(88);
    check("R8 clear at thr-2", int'(shutdown_out), 0);
    measure(d, h);
    check("R8 override released", h, 0);
  endtask

  initial begin
    t_reset();
    t_below();
    t_start_step();
    t_linear();
    t_slew_up();
    t_hold();
    t_throttle();
    t_slew_down();
    t_shutdown();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190_000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule